// File: doc/BRIEF.md
# Register-Mapped Signed Integer Divider

This peripheral divides one signed 32-bit number by another when software asks it to. Software writes the two operands into data registers over a simple synchronous register bus. It then writes a one to the go bit of the control word. An iterative shift-subtract engine works out the quotient and remainder over a fixed number of clock cycles. When it finishes, it places them in read-only result registers.

Completion shows as a status bit in the control word. That bit is high out of reset, falls as soon as a calculation is accepted, and rises again when the results are valid. A separate status bit reports a zero divisor. A zero divisor finishes after a single cycle with defined results. Both status bits clear on every accepted start.

Top module: `divq_periph`

## Requirements
- R1: After reset the control word (byte offset 0x000) reads 0x0000_0008, and the dividend (0x004), divisor (0x008), quotient (0x00C) and remainder (0x010) registers read zero.
- R2: The dividend and divisor registers read back the last value written to their offsets.
- R3: In the control word, bit 0 is the go bit and always reads 0, bit 3 is the done flag, bit 2 is the zero-divisor flag, and every other bit reads 0. A control write with bit 0 clear starts nothing and leaves the flags unchanged.
- R4: A control write with bit 0 set, made while idle, clears both flags on the same clock edge. For a nonzero divisor the done flag is 0 after 32 further edges and 1 after 33.
- R5: Operands and results are signed two's complement. The quotient truncates toward zero, and the remainder takes the sign of the dividend.
- R6: With a zero divisor, the done flag and the zero-divisor flag are both set one edge after the start. The quotient reads 0xFFFF_FFFF and the remainder equals the dividend.
- R7: A start written while a calculation is running is ignored. The running calculation finishes on its original schedule, using the operands it latched at its own start, even if the operand registers have been rewritten since.
- R8: Writes to the quotient and remainder offsets are ignored, and reads of any unmapped offset return zero.
- R9: Dividing 0x8000_0000 by -1 yields quotient 0x8000_0000 and remainder 0, and the zero-divisor flag stays clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Byte address of the register access |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Read data, valid in the same cycle as rd_en_i, zero when rd_en_i is low |

## Verification
The divider is run with all four sign combinations of one operand pair. These distinguish truncation toward zero from floor division, and a remainder that follows the dividend's sign from one that follows the divisor's. A dividend smaller than the divisor checks the zero-quotient path. The largest positive value divided by one exercises every quotient bit. The most negative value divided by -1 isolates the overflow case. A zero divisor, and a second start issued during a running calculation with a zero divisor already written, show that the short path is taken only when chosen at start time. The done flag is sampled one edge before and exactly on the expected completion edge, which pins the latency.

// File: rtl/divq_pkg.sv
package divq_pkg;
  localparam int unsigned OFS_CTRL = 'h000;
  localparam int unsigned OFS_DVD  = 'h004;
  localparam int unsigned OFS_DSR  = 'h008;
  localparam int unsigned OFS_QUO  = 'h00C;
  localparam int unsigned OFS_REM  = 'h010;

  localparam int unsigned GO_BIT   = 0;
  localparam int unsigned ZDIV_BIT = 2;
  localparam int unsigned DONE_BIT = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ITER = 2'd1,
    ST_FIX  = 2'd2,
    ST_ZERO = 2'd3
  } divq_state_e;
endpackage

// File: rtl/divq_negate.sv
module divq_negate #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] val_i,
  input  logic         neg_i,
  output logic [W-1:0] val_o
);
  localparam logic [W-1:0] ONE = W'(1);
  assign val_o = neg_i ? (~val_i + ONE) : val_i;
endmodule

// File: rtl/divq_engine.sv
module divq_engine
  import divq_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] dividend_i,
  input  logic [DW-1:0] divisor_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          zdiv_o,
  output logic [DW-1:0] quot_o,
  output logic [DW-1:0] rem_o
);
  localparam int unsigned CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  divq_state_e   state_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] den_q, quo_q;
  logic [DW:0]   acc_q;
  logic          negq_q, negr_q;

  logic [DW-1:0] dvd_abs, dsr_abs, quo_fix, rem_fix;
  logic [DW:0]   shifted, diff;
  logic          take;

  divq_negate #(.W(DW)) u_abs_dvd (.val_i(dividend_i), .neg_i(dividend_i[DW-1]), .val_o(dvd_abs));
  divq_negate #(.W(DW)) u_abs_dsr (.val_i(divisor_i),  .neg_i(divisor_i[DW-1]),  .val_o(dsr_abs));
  divq_negate #(.W(DW)) u_fix_quo (.val_i(quo_q),          .neg_i(negq_q), .val_o(quo_fix));
  divq_negate #(.W(DW)) u_fix_rem (.val_i(acc_q[DW-1:0]),  .neg_i(negr_q), .val_o(rem_fix));

  // restoring step: shift in next dividend bit, trial subtract
  assign shifted = {acc_q[DW-1:0], quo_q[DW-1]};
  assign diff    = shifted - {1'b0, den_q};
  assign take    = ~diff[DW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      den_q   <= '0;
      quo_q   <= '0;
      acc_q   <= '0;
      negq_q  <= 1'b0;
      negr_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            cnt_q <= '0;
            if (divisor_i == '0) begin
              state_q <= ST_ZERO;
              acc_q   <= {1'b0, dividend_i};
              negq_q  <= 1'b0;
              negr_q  <= 1'b0;
            end else begin
              state_q <= ST_ITER;
              acc_q   <= '0;
              quo_q   <= dvd_abs;
              den_q   <= dsr_abs;
              negq_q  <= dividend_i[DW-1] ^ divisor_i[DW-1];
              negr_q  <= dividend_i[DW-1];
            end
          end
        end
        ST_ITER: begin
          acc_q <= take ? diff : shifted;
          quo_q <= {quo_q[DW-2:0], take};
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) state_q <= ST_FIX;
        end
        ST_FIX:  state_q <= ST_IDLE;
        ST_ZERO: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_FIX) || (state_q == ST_ZERO);
  assign zdiv_o = (state_q == ST_ZERO);
  assign quot_o = (state_q == ST_ZERO) ? '1 : quo_fix;
  assign rem_o  = rem_fix;

  // R7: a start while iterating must not reload the latched operands
  a_r7_no_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ITER && start_i) |=> ($stable(den_q) && $stable(negq_q) && $stable(negr_q)));

  // R5: remainder magnitude stays below divisor magnitude at completion
  a_r5_rem_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FIX) |-> (acc_q < {1'b0, den_q}));
endmodule

// File: rtl/divq_periph.sv
module divq_periph
  import divq_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DW     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic              rd_en_i,
  output logic [DW-1:0]     rd_data_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_DVD  = ADDR_W'(OFS_DVD);
  localparam logic [ADDR_W-1:0] A_DSR  = ADDR_W'(OFS_DSR);
  localparam logic [ADDR_W-1:0] A_QUO  = ADDR_W'(OFS_QUO);
  localparam logic [ADDR_W-1:0] A_REM  = ADDR_W'(OFS_REM);
  localparam int unsigned CKW = $clog2(DW + 2) + 1;

  logic [DW-1:0] dvd_q, dsr_q, quo_q, rem_q;
  logic          done_q, zdiv_q;
  logic          start_acc;
  logic          eng_busy, eng_done, eng_zdiv;
  logic [DW-1:0] eng_quot, eng_rem;

  assign start_acc = wr_en_i && (addr_i == A_CTRL) && wr_data_i[GO_BIT] && !eng_busy;

  divq_engine #(.DW(DW)) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_acc),
    .dividend_i (dvd_q),
    .divisor_i  (dsr_q),
    .busy_o     (eng_busy),
    .done_o     (eng_done),
    .zdiv_o     (eng_zdiv),
    .quot_o     (eng_quot),
    .rem_o      (eng_rem)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dvd_q  <= '0;
      dsr_q  <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
      done_q <= 1'b1;
      zdiv_q <= 1'b0;
    end else begin
      if (wr_en_i && addr_i == A_DVD) dvd_q <= wr_data_i;
      if (wr_en_i && addr_i == A_DSR) dsr_q <= wr_data_i;
      if (start_acc) begin
        done_q <= 1'b0;
        zdiv_q <= 1'b0;
      end else if (eng_done) begin
        done_q <= 1'b1;
        zdiv_q <= eng_zdiv;
        quo_q  <= eng_quot;
        rem_q  <= eng_rem;
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_en_i) begin
      unique case (addr_i)
        A_CTRL: begin
          rd_data_o[DONE_BIT] = done_q;
          rd_data_o[ZDIV_BIT] = zdiv_q;
        end
        A_DVD:   rd_data_o = dvd_q;
        A_DSR:   rd_data_o = dsr_q;
        A_QUO:   rd_data_o = quo_q;
        A_REM:   rd_data_o = rem_q;
        default: rd_data_o = '0;
      endcase
    end
  end

  // cycle counter since accepted start, for latency checks
  logic [CKW-1:0] chk_cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        chk_cyc_q <= '0;
    else if (start_acc) chk_cyc_q <= '0;
    else if (eng_busy)  chk_cyc_q <= chk_cyc_q + 1'b1;
  end

  a_r4_clear_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_acc |=> (!done_q && !zdiv_q));

  a_r4_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_done && !eng_zdiv) |-> (chk_cyc_q == CKW'(DW)));

  a_r6_zero_fast: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_done && eng_zdiv) |-> (chk_cyc_q == '0));

  a_r6_zero_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_done && eng_zdiv) |=> (done_q && zdiv_q && quo_q == '1));

  a_r8_quo_ro: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_QUO && !eng_done) |=> $stable(quo_q));

  a_r3_ctrl_rsvd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == A_CTRL) |-> (rd_data_o[GO_BIT] == 1'b0 && rd_data_o[DW-1:4] == '0));
endmodule

// File: tb/divq_periph_tb_top.sv
module divq_periph_tb_top;
  localparam int DW = 32;
  localparam logic [11:0] A_CTRL = 12'h000, A_DVD = 12'h004, A_DSR = 12'h008,
                          A_QUO = 12'h00C, A_REM = 12'h010;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wr_data = '0, rd_data;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  divq_periph dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_data_o(rd_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    #0.5;
    d = rd_data;
    rd_en = 1'b0;
  endtask

  function automatic void model(input logic [31:0] a, input logic [31:0] b,
                                output logic [31:0] q, output logic [31:0] r);
    int sa, sb;
    sa = int'(a); sb = int'(b);
    if (b == 32'd0) begin q = 32'hFFFF_FFFF; r = a; end
    else if (b == 32'hFFFF_FFFF) begin q = -a; r = 32'd0; end
    else begin q = 32'(sa / sb); r = 32'(sa % sb); end
  endfunction

  // full division run: latency, flags, results
  task automatic t_div(input string req, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] q, r, v;
    int lat;
    model(a, b, q, r);
    lat = (b == 0) ? 1 : DW + 1;
    bus_wr(A_DVD, a);
    bus_wr(A_DSR, b);
    bus_wr(A_CTRL, 32'h1);
    bus_rd(A_CTRL, v);
    check({req, " R4 flags cleared"}, v, 32'h0);
    for (int k = 1; k <= lat; k++) begin
      @(posedge clk); #1;
      if (k == lat - 1 && lat > 1) begin
        bus_rd(A_CTRL, v); check({req, " R4 not done early"}, v, 32'h0);
      end
    end
    bus_rd(A_CTRL, v);
    check({req, " R4/R6 done flag"}, v, (b == 0) ? 32'hC : 32'h8);
    bus_rd(A_QUO, v); check({req, " quotient"}, v, q);
    bus_rd(A_REM, v); check({req, " remainder"}, v, r);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    bus_rd(A_CTRL, v); check("R1 ctrl", v, 32'h8);
    bus_rd(A_DVD, v);  check("R1 dvd", v, 0);
    bus_rd(A_DSR, v);  check("R1 dsr", v, 0);
    bus_rd(A_QUO, v);  check("R1 quo", v, 0);
    bus_rd(A_REM, v);  check("R1 rem", v, 0);
  endtask

  task automatic t_readback;
    logic [31:0] v;
    bus_wr(A_DVD, 32'hDEAD_BEEF); bus_wr(A_DSR, 32'h1234_5678);
    bus_rd(A_DVD, v); check("R2 dvd readback", v, 32'hDEAD_BEEF);
    bus_rd(A_DSR, v); check("R2 dsr readback", v, 32'h1234_5678);
  endtask

  task automatic t_ctrl_bits;
    logic [31:0] v;
    bus_wr(A_CTRL, 32'hFFFF_FFFE);
    @(posedge clk); #1;
    bus_rd(A_CTRL, v); check("R3 go=0 no start, reserved zero", v, 32'h8);
    bus_wr(A_DVD, 32'd50); bus_wr(A_DSR, 32'd3);
    bus_wr(A_CTRL, 32'h1);
    repeat (3) @(posedge clk); #1;
    bus_rd(A_CTRL, v); check("R3 go reads 0 while busy", v, 32'h0);
    repeat (40) @(posedge clk); #1;
  endtask

  task automatic t_busy_start;
    logic [31:0] v;
    bus_wr(A_DVD, 32'd100); bus_wr(A_DSR, 32'd7);
    bus_wr(A_CTRL, 32'h1);                      // edge E
    bus_wr(A_DSR, 32'd0);                       // E+1
    bus_wr(A_CTRL, 32'h1);                      // E+2, ignored
    for (int k = 3; k <= DW + 1; k++) begin
      @(posedge clk); #1;
      if (k == DW) begin bus_rd(A_CTRL, v); check("R7 still busy", v, 32'h0); end
    end
    bus_rd(A_CTRL, v); check("R7 original completion", v, 32'h8);
    bus_rd(A_QUO, v);  check("R7 quotient from latched ops", v, 32'd14);
    bus_rd(A_REM, v);  check("R7 remainder from latched ops", v, 32'd2);
    bus_rd(A_DSR, v);  check("R7 divisor reg rewritten", v, 32'd0);
  endtask

  task automatic t_ro_unmapped;
    logic [31:0] q0, r0, v;
    bus_rd(A_QUO, q0); bus_rd(A_REM, r0);
    bus_wr(A_QUO, 32'h1234_5678); bus_wr(A_REM, 32'h8765_4321);
    bus_rd(A_QUO, v); check("R8 quotient write ignored", v, q0);
    bus_rd(A_REM, v); check("R8 remainder write ignored", v, r0);
    bus_rd(12'h014, v); check("R8 unmapped 0x014", v, 0);
    bus_rd(12'h0FC, v); check("R8 unmapped 0x0FC", v, 0);
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_readback();
    t_ctrl_bits();
    t_div("R5 pos/pos", 32'd100, 32'd7);
    t_div("R5 neg/pos", -32'sd100, 32'd7);
    t_div("R5 pos/neg", 32'd100, -32'sd7);
    t_div("R5 neg/neg", -32'sd100, -32'sd7);
    t_div("R5 small/large", 32'd5, 32'd10);
    t_div("R5 max/1", 32'h7FFF_FFFF, 32'd1);
    t_div("R9 min/-1", 32'h8000_0000, 32'hFFFF_FFFF);
    t_div("R6 zero divisor", -32'sd37, 32'd0);
    t_div("R4 after zero", 32'd1000, 32'd33);
    t_busy_start();
    t_ro_unmapped();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule